// File: doc/BRIEF.md
# ARINC Receiver Hub SPI Command Interface

This block is the serial slave front end of a multi-channel ARINC 429 receiver hub. A host selects the block with an active-low chip select and clocks an 8-bit command byte into it. The upper nibble of that byte names a receive channel and the lower nibble names an operation. A data field follows whose length the operation fixes: none, 16, 32 or 128 bits. Writes land in per-channel control registers, in per-channel label tables or in a transmit word holding register. Reads return a label table, a control register, the head word of a receive FIFO, or a combined FIFO status word.

The receive FIFOs and the transmitter sit outside the block. Each FIFO is seen as a head word, an empty flag and a full flag, and the block answers with one-cycle pop and clear strobes. The transmitter is seen as a word, a speed bit and a load strobe. SPI pins are sampled in the system clock domain and are assumed already synchronous and slow against it (mode 0, clock idle low). Serial output drive is qualified by a separate enable, so the tri-state buffer lives in the pad ring.

Top module: `a429_spi_cmd`

## Requirements
- R1: After chip select falls, the first 8 rising serial clock edges shift in the command MSB first. Bits 7:4 give the channel (1 to NCH valid), and bits 3:0 give the operation. A channel operation (codes 1 to 5) whose channel is 0 or above NCH has no effect, and its read returns zeros.
- R2: Code 4 with a 16-bit field writes the channel's control register, stored with bits 15:10 forced to 0, and pulses that channel's `fifo_clear` once. Code 5 returns the register MSB first, with the first bit driven after the falling edge that follows the eighth rising edge.
- R3: Code 1 with a 128-bit field loads the channel's 16-label table. Code 2 returns the same 128 bits in the same order.
- R4: Code 3 returns the channel's FIFO head word (32 bits), or all zeros when the FIFO is empty. Exactly one `fifo_pop` pulse for that channel follows the 32nd data rising edge, and only if the FIFO was non-empty.
- R5: Code 6 returns 16 status bits. Bit k (k = 0..7) is the empty flag of channel k+1, and bit 8+k is the full flag of channel k+1.
- R6: Code 7 gives one `master_reset` pulse whatever the channel nibble, and leaves every control register unchanged.
- R7: Codes 8 and 9 with a 32-bit field give `tx_word` and one `tx_load` pulse. `tx_fast` is 1 for code 8 and 0 for code 9.
- R8: Codes 0 and 10 to 15 change no register and raise no strobe.
- R9: If chip select rises before a write field or a FIFO read field is complete, nothing is committed and no pop is issued.
- R10: `spi_miso_en` is 0 one clock after chip select is high. It is 1 during the data phase of a read.
- R11: After reset, control registers and label tables read zero and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_en | output | 1 | Drive enable for serial data out |
| fifo_head | input | NCH*32 | Head word of each receive FIFO |
| fifo_empty | input | NCH | FIFO empty flag per channel |
| fifo_full | input | NCH | FIFO full flag per channel |
| fifo_pop | output | NCH | One-cycle pop strobe per channel |
| fifo_clear | output | NCH | One-cycle clear strobe per channel |
| ctrl_regs | output | NCH*16 | Control register contents, channel 1 in low bits |
| label_regs | output | NCH*128 | Label tables, channel 1 in low bits |
| master_reset | output | 1 | One-cycle global reset strobe |
| tx_load | output | 1 | One-cycle transmit load strobe |
| tx_fast | output | 1 | 1 = high speed, 0 = low speed |
| tx_word | output | 32 | Transmit word |

## Verification
Every commit and strobe is registered. Each one appears one clock after the clock edge that first samples the final serial rising edge of its field. Read data changes on the system clock after a sampled falling serial edge. The bench holds each serial level for three system clocks. It reads the output bit just before it raises the serial clock, and it checks registers and strobe counters only after chip select has gone high and four more clocks have passed. That puts every sample well after the cycle its result is due.

// File: rtl/a429_spi_pkg.sv
// Shared command codes and field lengths for the ARINC hub serial interface.
// Assumes a 4-bit operation code in the low nibble of the command byte.
package a429_spi_pkg;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_LBL_WR  = 4'd1,
        OP_LBL_RD  = 4'd2,
        OP_FIFO_RD = 4'd3,
        OP_CTL_WR  = 4'd4,
        OP_CTL_RD  = 4'd5,
        OP_STAT_RD = 4'd6,
        OP_MRST    = 4'd7,
        OP_TX_HI   = 4'd8,
        OP_TX_LO   = 4'd9
    } op_e;

    // True for operations that address a single channel.
    function automatic logic is_chan_op(input logic [3:0] op);
        return (op >= 4'd1) && (op <= 4'd5);
    endfunction

    // True for operations that drive a data field out.
    function automatic logic is_read_op(input logic [3:0] op);
        return (op == OP_LBL_RD) || (op == OP_FIFO_RD) ||
               (op == OP_CTL_RD) || (op == OP_STAT_RD);
    endfunction

endpackage

// File: rtl/spi_edge_frame.sv
// Serial clock edge detector and frame bit counter.
// Assumes chip select and serial clock are synchronous to clk and that the
// serial clock idles low. Counts rising edges since chip select fell and
// saturates at the counter maximum.
module spi_edge_frame #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sck,
    output logic          rise,
    output logic          fall,
    output logic [CW-1:0] cnt
);
    logic sck_q;

    // Remember the last sampled serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign rise = !cs_n && sck && !sck_q;
    assign fall = !cs_n && !sck && sck_q;

    // Count rising edges within the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n)           cnt <= '0;
        else if (rise && cnt != '1)   cnt <= cnt + 1'b1;
    end

    p_cnt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cnt == '0));

endmodule

// File: rtl/spi_data_path.sv
// Serial shift registers: input shifts MSB first on each rising edge, output
// is loaded in parallel and presents one bit per falling edge, MSB first.
// Assumes load and fall never coincide (load comes from a rising edge).
module spi_data_path #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         rise,
    input  logic         fall,
    input  logic         mosi,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] rx_q,
    output logic         out_bit
);
    logic [W-1:0] tx_q;

    // Collect incoming bits.
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_q <= '0;
        else if (rise) rx_q <= {rx_q[W-2:0], mosi};
    end

    // Present outgoing bits on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            tx_q    <= '0;
            out_bit <= 1'b0;
        end else if (load) begin
            tx_q    <= load_val;
        end else if (fall) begin
            out_bit <= tx_q[W-1];
            tx_q    <= {tx_q[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/chan_regfile.sv
// Per-channel control registers and label tables.
// Assumes at most one channel write strobe per cycle; unused control bits
// are stored as zero.
module chan_regfile #(
    parameter int NCH       = 8,
    parameter int CTRL_W    = 16,
    parameter int CTRL_USED = 10,
    parameter int LBL_W     = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        wr_ctrl,
    input  logic [NCH-1:0]        wr_lbl,
    input  logic [LBL_W-1:0]      wdata,
    output logic [NCH*CTRL_W-1:0] ctrl_flat,
    output logic [NCH*LBL_W-1:0]  lbl_flat
);
    localparam logic [CTRL_W-1:0] CTRL_MASK = CTRL_W'((1 << CTRL_USED) - 1);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Hold one channel's control word.
        always_ff @(posedge clk) begin
            if (!rst_n)          ctrl_flat[g*CTRL_W +: CTRL_W] <= '0;
            else if (wr_ctrl[g]) ctrl_flat[g*CTRL_W +: CTRL_W] <= wdata[CTRL_W-1:0] & CTRL_MASK;
        end
        // Hold one channel's label table.
        always_ff @(posedge clk) begin
            if (!rst_n)         lbl_flat[g*LBL_W +: LBL_W] <= '0;
            else if (wr_lbl[g]) lbl_flat[g*LBL_W +: LBL_W] <= wdata;
        end
    end

    p_ctrl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl == '0) |=> $stable(ctrl_flat));
    p_lbl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lbl == '0) |=> $stable(lbl_flat));
    p_one_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_ctrl | wr_lbl));

endmodule

// File: rtl/a429_spi_cmd.sv
// Serial command decoder for a multi-channel ARINC receiver hub.
// Decodes an 8-bit command (channel nibble, operation nibble), then shifts a
// field of 0, 16, 32 or 128 bits in or out. Assumes synchronous, mode-0
// serial inputs sampled by clk and NCH at most 15.
module a429_spi_cmd
    import a429_spi_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int LBL_BYTES = 16,
    parameter int CTRL_W    = 16,
    parameter int CTRL_USED = 10,
    parameter int WORD_W    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      spi_cs_n,
    input  logic                      spi_sck,
    input  logic                      spi_mosi,
    output logic                      spi_miso,
    output logic                      spi_miso_en,
    input  logic [NCH*WORD_W-1:0]     fifo_head,
    input  logic [NCH-1:0]            fifo_empty,
    input  logic [NCH-1:0]            fifo_full,
    output logic [NCH-1:0]            fifo_pop,
    output logic [NCH-1:0]            fifo_clear,
    output logic [NCH*CTRL_W-1:0]     ctrl_regs,
    output logic [NCH*LBL_BYTES*8-1:0] label_regs,
    output logic                      master_reset,
    output logic                      tx_load,
    output logic                      tx_fast,
    output logic [WORD_W-1:0]         tx_word
);
    localparam int LBL_W  = LBL_BYTES * 8;
    localparam int SH_W   = LBL_W;
    localparam int CMD_W  = 8;
    localparam int CW     = $clog2(CMD_W + SH_W + 1);
    localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int STAT_W = 2 * NCH;
    localparam logic [CW-1:0] AT_CMD  = CW'(CMD_W - 1);
    localparam logic [CW-1:0] AT_CTRL = CW'(CMD_W - 1 + CTRL_W);
    localparam logic [CW-1:0] AT_WORD = CW'(CMD_W - 1 + WORD_W);
    localparam logic [CW-1:0] AT_LBL  = CW'(CMD_W - 1 + LBL_W);

    logic          rise, fall, out_bit, dec;
    logic [CW-1:0] cnt;
    logic [SH_W-1:0] rx_q, rd_val, wfull;
    logic [7:0]    cmd_now;
    op_e           op_now, op_q;
    logic [3:0]    ch_now, ch_m1;
    logic [CHW-1:0] idx_now, idx_q;
    logic          ok_now, ok_q, pop_arm_q, en_q;
    logic [NCH-1:0] sel_q, wr_ctrl, wr_lbl;

    spi_edge_frame #(.CW(CW)) u_edge (
        .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck),
        .rise(rise), .fall(fall), .cnt(cnt)
    );

    spi_data_path #(.W(SH_W)) u_path (
        .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .rise(rise), .fall(fall),
        .mosi(spi_mosi), .load(dec), .load_val(rd_val), .rx_q(rx_q),
        .out_bit(out_bit)
    );

    chan_regfile #(.NCH(NCH), .CTRL_W(CTRL_W), .CTRL_USED(CTRL_USED), .LBL_W(LBL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_lbl(wr_lbl),
        .wdata(wfull), .ctrl_flat(ctrl_regs), .lbl_flat(label_regs)
    );

    // Decode the command byte as its last bit arrives.
    always_comb begin
        cmd_now = {rx_q[6:0], spi_mosi};
        wfull   = {rx_q[SH_W-2:0], spi_mosi};
        op_now  = op_e'(cmd_now[3:0]);
        ch_now  = cmd_now[7:4];
        ch_m1   = ch_now - 4'd1;
        idx_now = ch_m1[CHW-1:0];
        ok_now  = (ch_now != 4'd0) && (int'(ch_now) <= NCH);
        dec     = rise && (cnt == AT_CMD);
    end

    // Select the value that the read field will carry, MSB aligned.
    always_comb begin
        rd_val = '0;
        case (op_now)
            OP_LBL_RD:  if (ok_now) rd_val = label_regs[idx_now*LBL_W +: LBL_W];
            OP_FIFO_RD: if (ok_now && !fifo_empty[idx_now])
                            rd_val[SH_W-1 -: WORD_W] = fifo_head[idx_now*WORD_W +: WORD_W];
            OP_CTL_RD:  if (ok_now) rd_val[SH_W-1 -: CTRL_W] = ctrl_regs[idx_now*CTRL_W +: CTRL_W];
            OP_STAT_RD: rd_val[SH_W-1 -: STAT_W] = {fifo_full, fifo_empty};
            default:    rd_val = '0;
        endcase
    end

    // Remember the decoded command for the rest of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= OP_NOP;
            idx_q <= '0;
            ok_q  <= 1'b0;
        end else if (dec) begin
            op_q  <= op_now;
            idx_q <= idx_now;
            ok_q  <= ok_now || !is_chan_op(op_now);
        end
    end

    assign sel_q = NCH'(1) << idx_q;

    // Raise channel write strobes when a complete field has arrived.
    always_comb begin
        wr_ctrl = '0;
        wr_lbl  = '0;
        if (rise && ok_q && op_q == OP_CTL_WR && cnt == AT_CTRL) wr_ctrl = sel_q;
        if (rise && ok_q && op_q == OP_LBL_WR && cnt == AT_LBL)  wr_lbl  = sel_q;
    end

    // Arm a pop for a non-empty FIFO read and drive the output enable.
    always_ff @(posedge clk) begin
        if (!rst_n || spi_cs_n) begin
            pop_arm_q <= 1'b0;
            en_q      <= 1'b0;
        end else if (dec) begin
            pop_arm_q <= (op_now == OP_FIFO_RD) && ok_now && !fifo_empty[idx_now];
            en_q      <= is_read_op(op_now);
        end else if (rise && cnt == AT_WORD) begin
            pop_arm_q <= 1'b0;
        end
    end

    // Produce the registered strobes and the transmit word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_pop     <= '0;
            fifo_clear   <= '0;
            master_reset <= 1'b0;
            tx_load      <= 1'b0;
            tx_fast      <= 1'b0;
            tx_word      <= '0;
        end else begin
            fifo_clear   <= wr_ctrl;
            fifo_pop     <= '0;
            tx_load      <= 1'b0;
            master_reset <= dec && (op_now == OP_MRST);
            if (rise && cnt == AT_WORD && pop_arm_q && op_q == OP_FIFO_RD)
                fifo_pop <= sel_q;
            if (rise && cnt == AT_WORD && (op_q == OP_TX_HI || op_q == OP_TX_LO)) begin
                tx_load <= 1'b1;
                tx_word <= wfull[WORD_W-1:0];
                tx_fast <= (op_q == OP_TX_HI);
            end
        end
    end

    assign spi_miso    = out_bit;
    assign spi_miso_en = en_q;

    p_miso_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |=> !spi_miso_en);
    p_pop_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_pop));
    p_pop_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop != '0) |=> (fifo_pop == '0));
    p_clear_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_clear));
    p_tx_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load);
    p_mrst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        master_reset |=> !master_reset);

endmodule

// File: tb/test_a429_spi_cmd.sv
module test_a429_spi_cmd;
    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso, miso_en;
    logic [NCH*32-1:0] fifo_head = '0;
    logic [NCH-1:0] fifo_empty = '1, fifo_full = '0;
    logic [NCH-1:0] fifo_pop, fifo_clear;
    logic [NCH*16-1:0] ctrl_regs;
    logic [NCH*128-1:0] label_regs;
    logic master_reset, tx_load, tx_fast;
    logic [31:0] tx_word;

    int n_chk = 0, n_fail = 0;
    int pop_cnt = 0, clr_cnt = 0, mr_cnt = 0, txl_cnt = 0;
    logic [NCH-1:0] pop_or = '0, clr_or = '0;
    logic [15:0] exp_ctrl [NCH];
    logic [127:0] exp_lbl [NCH];
    logic en_seen;

    always #2 clk = ~clk;

    a429_spi_cmd i_a429_spi_cmd (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_en(miso_en), .fifo_head(fifo_head),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_pop(fifo_pop),
        .fifo_clear(fifo_clear), .ctrl_regs(ctrl_regs), .label_regs(label_regs),
        .master_reset(master_reset), .tx_load(tx_load), .tx_fast(tx_fast),
        .tx_word(tx_word)
    );

    always @(posedge clk) begin
        if (fifo_pop != '0)   begin pop_cnt++; pop_or |= fifo_pop; end
        if (fifo_clear != '0) begin clr_cnt++; clr_or |= fifo_clear; end
        if (master_reset) mr_cnt++;
        if (tx_load) txl_cnt++;
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr_counts();
        pop_cnt = 0; clr_cnt = 0; mr_cnt = 0; txl_cnt = 0;
        pop_or = '0; clr_or = '0;
    endtask

    // One frame: command byte, then nbits of field, MSB first; read bits returned.
    task automatic xfer(input logic [7:0] cmd, input logic [127:0] wd, input int nbits,
                        output logic [127:0] rd);
        logic [135:0] sh;
        sh = {cmd, wd << (128 - nbits)};
        rd = '0;
        en_seen = 1'b0;
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 8 + nbits; i++) begin
            sck = 1'b0;
            mosi = sh[135];
            sh = sh << 1;
            repeat (3) @(negedge clk);
            if (i >= 8) begin
                rd = {rd[126:0], miso};
                if (i == 8) en_seen = miso_en;
            end
            sck = 1'b1;
            repeat (3) @(negedge clk);
        end
        sck = 1'b0;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [127:0] all_ctrl_exp();
        logic [127:0] v;
        for (int c = 0; c < NCH; c++) v[c*16 +: 16] = exp_ctrl[c];
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] rd, v;
        logic [7:0] cmd;
        int ch;
        void'($urandom(32'd4242));
        for (int c = 0; c < NCH; c++) begin exp_ctrl[c] = '0; exp_lbl[c] = '0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11 reset state
        check("R11 ctrl", {ctrl_regs}, '0);
        check("R11 labels", {127'd0, |label_regs}, '0);
        check("R11 strobes", {fifo_pop, fifo_clear, master_reset, tx_load, miso_en}, '0);

        // R2 control writes with random data, read back and clear strobe
        for (int c = 0; c < NCH; c++) begin
            v = 128'($urandom());
            clr_counts();
            xfer({4'(c + 1), 4'h4}, v, 16, rd);
            exp_ctrl[c] = v[15:0] & 16'h03FF;
            check("R2 clear strobe", {clr_cnt[7:0], clr_or}, {8'd1, NCH'(1) << c});
            xfer({4'(c + 1), 4'h5}, '0, 16, rd);
            check("R2 readback", rd, {112'd0, exp_ctrl[c]});
            check("R10 enable during read", en_seen, 1'b1);
        end
        check("R2 port", ctrl_regs, all_ctrl_exp());
        check("R10 idle enable", miso_en, 1'b0);

        // R1 out-of-range channels ignored
        foreach (cmd[i]) ;
        for (int k = 9; k <= 16; k++) begin
            clr_counts();
            xfer({4'(k == 16 ? 0 : k), 4'h4}, 128'hFFFF, 16, rd);
            check("R1 bad channel write", {clr_cnt, ctrl_regs}, {32'd0, all_ctrl_exp()});
        end
        xfer(8'h05, '0, 16, rd);
        check("R1 bad channel read", rd, '0);

        // R3 label table load and readback
        for (int n = 0; n < 3; n++) begin
            ch = int'($urandom_range(0, NCH - 1));
            v = {$urandom(), $urandom(), $urandom(), $urandom()};
            xfer({4'(ch + 1), 4'h1}, v, 128, rd);
            exp_lbl[ch] = v;
            xfer({4'(ch + 1), 4'h2}, '0, 128, rd);
            check("R3 readback", rd, v);
            check("R3 port", label_regs[ch*128 +: 128], v);
        end

        // R4 FIFO reads: non-empty, empty, aborted
        for (int n = 0; n < 6; n++) begin
            ch = int'($urandom_range(0, NCH - 1));
            for (int c = 0; c < NCH; c++) fifo_head[c*32 +: 32] = $urandom();
            fifo_empty = NCH'($urandom());
            clr_counts();
            xfer({4'(ch + 1), 4'h3}, '0, 32, rd);
            if (fifo_empty[ch]) begin
                check("R4 empty reads zero", rd, '0);
                check("R4 no pop when empty", pop_cnt, 0);
            end else begin
                check("R4 head word", rd, {96'd0, fifo_head[ch*32 +: 32]});
                check("R4 single pop", {pop_cnt[7:0], pop_or}, {8'd1, NCH'(1) << ch});
            end
        end
        fifo_empty = '0;
        clr_counts();
        xfer(8'h23, '0, 20, rd);
        check("R9 aborted read no pop", pop_cnt, 0);

        // R5 status word
        for (int n = 0; n < 4; n++) begin
            fifo_empty = NCH'($urandom());
            fifo_full  = NCH'($urandom());
            xfer({4'($urandom_range(0, 15)), 4'h6}, '0, 16, rd);
            check("R5 status", rd, {112'd0, fifo_full, fifo_empty});
        end

        // R6 master reset
        clr_counts();
        xfer({4'($urandom_range(0, 15)), 4'h7}, '0, 0, rd);
        check("R6 one pulse", mr_cnt, 1);
        check("R6 ctrl kept", ctrl_regs, all_ctrl_exp());

        // R7 transmit loads at both speeds
        for (int n = 0; n < 4; n++) begin
            v = 128'($urandom());
            clr_counts();
            cmd = {4'($urandom_range(0, 15)), (n[0] ? 4'h9 : 4'h8)};
            xfer(cmd, v, 32, rd);
            check("R7 word", tx_word, v[31:0]);
            check("R7 speed", tx_fast, !n[0]);
            check("R7 one load", txl_cnt, 1);
        end

        // R8 undefined codes change nothing
        v = {96'd0, tx_word};
        for (int op = 0; op < 16; op++) begin
            if (op >= 1 && op <= 9) continue;
            clr_counts();
            xfer({4'h1, 4'(op)}, {$urandom(), $urandom(), $urandom(), $urandom()}, 128, rd);
            check("R8 no strobe", {pop_cnt, clr_cnt, mr_cnt, txl_cnt}, '0);
            check("R8 regs kept", {ctrl_regs == all_ctrl_exp(), label_regs[0 +: 128] == exp_lbl[0], tx_word == v[31:0]}, 3'b111);
        end

        // R9 aborted writes
        clr_counts();
        xfer(8'h34, 128'h3FF, 15, rd);
        check("R9 aborted ctrl", {clr_cnt, ctrl_regs}, {32'd0, all_ctrl_exp()});
        xfer(8'h21, '1, 127, rd);
        check("R9 aborted labels", label_regs[128 +: 128], exp_lbl[1]);
        clr_counts();
        xfer(8'h18, 128'hDEAD, 31, rd);
        check("R9 aborted tx", txl_cnt, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule